// File: doc/BRIEF.md
# Hex Load-Record Stream Parser

This block takes a stream of ASCII characters, one per cycle in which `in_valid` is high, that holds hexadecimal load records of the letter-S family. It splits each line into its record type, byte count, address field, payload and checksum, and keeps a running checksum as the bytes go by. Payload bytes of data records leave at once as single-byte memory writes. The write address starts at the record's load address and goes up by one for each byte.

When the line feed that closes a record arrives, the block raises a one-cycle completion pulse and reports whether the checksum matched. For a good termination record it gives the start execution address. For a good header record it raises a header pulse. For a good record-count record it compares the carried count with its own 16-bit count of good data records and reports whether they agree. Illegal characters and impossible byte counts give one-cycle error pulses, and the parser then waits for the next record start. Character transport and the target memory sit outside the block.

Top module: `srec_loader`

## Requirements
- R1: A record opens with the character 'S' (0x53) followed by one type digit from {0,1,2,3,5,7,8,9}. Characters that arrive while no record is open, other than 'S', produce no output. A type digit outside that set (4, 6, a letter or any other character) produces an `err_char` pulse.
- R2: The two hex characters after the type give the byte count, which covers the address, payload and checksum bytes. If the count is below address bytes + 1, or above address bytes + 1 + 32, the block pulses `err_len`, drops the record and emits no completion.
- R3: The address field is 2 bytes for types 0, 1, 5 and 9, 3 bytes for types 2 and 8, and 4 bytes for types 3 and 7. It is read most significant byte first.
- R4: Each payload byte of a type 1, 2 or 3 record is written once. The write carries `wr_data` = the byte and `wr_addr` = the load address plus the byte's index, in stream order. Payload bytes of other record types are never written.
- R5: The last byte of a record is the checksum. It must equal the low byte of the ones complement of the sum of the count, address and payload bytes. On the closing line feed, `rec_done` pulses with `rec_kind` = the type and `rec_csum_err` = 1 exactly when the checksum does not match. Writes already issued for that record stay issued.
- R6: A good type 7, 8 or 9 record pulses `start_valid` together with `rec_done`, with `start_addr` = the address field zero-extended to 32 bits.
- R7: A good type 0 record pulses `hdr_valid` together with `rec_done`.
- R8: The block counts good type 1/2/3 records in a 16-bit counter that starts at 0 after reset. A good type 5 record pulses `tally_valid`, and `tally_mismatch` = 1 when its 2-byte address field differs from that count.
- R9: Hex digits are accepted in both upper case (A-F) and lower case (a-f), with the same value.
- R10: Any non-hex character inside the type, count, address, payload or checksum fields, and any character other than CR or LF after the checksum, produces an `err_char` pulse and abandons the record. If that character is 'S', a new record opens at once. Otherwise the parser waits for the next 'S'.
- R11: A carriage return (0x0D) between the checksum and the line feed (0x0A) is ignored.
- R12: While reset is applied and after it is released, every pulse output (`wr_en`, `rec_done`, `start_valid`, `hdr_valid`, `tally_valid`, `err_char`, `err_len`) is 0 until characters arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A character is present on `in_char` this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe for one payload byte |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| rec_done | output | 1 | One-cycle pulse when a record closes with a line feed |
| rec_kind | output | 4 | Type digit of the current or last record |
| rec_csum_err | output | 1 | Checksum mismatch, valid with `rec_done` |
| start_valid | output | 1 | Start address available (good type 7/8/9) |
| start_addr | output | 32 | Start execution address |
| hdr_valid | output | 1 | Good header record seen |
| tally_valid | output | 1 | Good record-count record seen |
| tally_mismatch | output | 1 | Carried count differs from the internal count, valid with `tally_valid` |
| err_char | output | 1 | Illegal character pulse |
| err_len | output | 1 | Byte count out of range pulse |

## Verification
The bench sends records at the count boundaries: the smallest legal count and a full 32-byte payload, which must load, and counts one below the minimum and one above the maximum, which must be rejected. A parser with an off-by-one limit would drop a legal record or accept an oversized one. An 'S' in the middle of a broken record is followed directly by a termination record. A parser that did not restart on that character would lose the start address. The bench also sends a record with a bad checksum and then count records that agree and disagree with the tally. A design that counted failed records, or that withheld the writes, would report the wrong mismatch or miss expected writes. Lower-case digits, CR-LF endings, junk between records and a header payload that must not be written cover the remaining paths.

// File: rtl/srec_pkg.sv
package srec_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_TYPE,
    ST_COUNT,
    ST_ADDR,
    ST_BODY,
    ST_EOL
  } srec_state_e;

  localparam logic [7:0] CH_S  = 8'h53;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;

  // legal record type digits
  function automatic logic kind_legal(input logic [3:0] k);
    return (k == 4'd0) || (k == 4'd1) || (k == 4'd2) || (k == 4'd3) ||
           (k == 4'd5) || (k == 4'd7) || (k == 4'd8) || (k == 4'd9);
  endfunction

  // number of address bytes carried by a record type
  function automatic logic [2:0] kind_addr_bytes(input logic [3:0] k);
    logic [2:0] n;
    case (k)
      4'd2, 4'd8: n = 3'd3;
      4'd3, 4'd7: n = 3'd4;
      default:    n = 3'd2;
    endcase
    return n;
  endfunction

  function automatic logic kind_is_data(input logic [3:0] k);
    return (k == 4'd1) || (k == 4'd2) || (k == 4'd3);
  endfunction

  function automatic logic kind_is_start(input logic [3:0] k);
    return (k == 4'd7) || (k == 4'd8) || (k == 4'd9);
  endfunction

endpackage

// File: rtl/srec_char_class.sv
module srec_char_class
  import srec_pkg::*;
(
  input  logic [7:0] ch,
  output logic       is_hex,
  output logic [3:0] nib,
  output logic       is_s,
  output logic       is_lf,
  output logic       is_cr
);

  always_comb begin
    is_hex = 1'b0;
    nib    = 4'd0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h30);
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h37);
    end else if (ch >= 8'h61 && ch <= 8'h66) begin
      is_hex = 1'b1;
      nib    = 4'(ch - 8'h57);
    end
    is_s  = (ch == CH_S);
    is_lf = (ch == CH_LF);
    is_cr = (ch == CH_CR);
  end

endmodule

// File: rtl/srec_byte_pair.sv
module srec_byte_pair (
  input  logic       clk,
  input  logic       srst_n,
  input  logic       clr,
  input  logic       nib_valid,
  input  logic [3:0] nib,
  output logic       byte_valid,
  output logic [7:0] byte_out
);

  logic       have_hi, have_hi_n;
  logic [3:0] hi_q, hi_n;

  always_comb begin
    have_hi_n = have_hi;
    hi_n      = hi_q;
    if (clr) begin
      have_hi_n = 1'b0;
    end else if (nib_valid) begin
      have_hi_n = !have_hi;
      if (!have_hi) hi_n = nib;
    end
  end

  assign byte_valid = nib_valid && have_hi && !clr;
  assign byte_out   = {hi_q, nib};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      have_hi <= 1'b0;
      hi_q    <= 4'd0;
    end else begin
      have_hi <= have_hi_n;
      hi_q    <= hi_n;
    end
  end

endmodule

// File: rtl/srec_record_fsm.sv
module srec_record_fsm
  import srec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TALLY_W  = 16,
  parameter int MAX_DATA = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              in_valid,
  input  logic              is_hex,
  input  logic [3:0]        nib,
  input  logic              is_s,
  input  logic              is_lf,
  input  logic              is_cr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic              pair_clr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rec_done,
  output logic [3:0]        rec_kind,
  output logic              rec_csum_err,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_addr,
  output logic              hdr_valid,
  output logic              tally_valid,
  output logic              tally_mismatch,
  output logic              err_char,
  output logic              err_len
);

  localparam logic [8:0] MAX_DATA_C = 9'(MAX_DATA);

  srec_state_e       state, state_n;
  logic [3:0]        kind_n;
  logic [7:0]        cnt_rem, cnt_rem_n;
  logic [2:0]        addr_left, addr_left_n;
  logic [7:0]        sum_q, sum_n;
  logic [ADDR_W-1:0] field_q, field_n;
  logic [ADDR_W-1:0] wptr_q, wptr_n;
  logic              csum_ok_q, csum_ok_n;
  logic [TALLY_W-1:0] tally_q, tally_n;
  logic [8:0]        min_cnt, max_cnt;
  logic              bad;

  // pulse and data outputs (next values)
  logic              wr_en_n, done_n, cerr_n, sv_n, hdr_n, tv_n, tm_n, ec_n, el_n;
  logic [ADDR_W-1:0] wa_n, sa_n;
  logic [7:0]        wd_n;

  assign pair_clr = (state == ST_HUNT) || (state == ST_TYPE) || (state == ST_EOL);
  assign min_cnt  = {6'd0, addr_left} + 9'd1;
  assign max_cnt  = min_cnt + MAX_DATA_C;

  always_comb begin
    state_n     = state;
    kind_n      = rec_kind;
    cnt_rem_n   = cnt_rem;
    addr_left_n = addr_left;
    sum_n       = sum_q;
    field_n     = field_q;
    wptr_n      = wptr_q;
    csum_ok_n   = csum_ok_q;
    tally_n     = tally_q;
    wr_en_n     = 1'b0;
    wa_n        = wr_addr;
    wd_n        = wr_data;
    done_n      = 1'b0;
    cerr_n      = 1'b0;
    sv_n        = 1'b0;
    sa_n        = start_addr;
    hdr_n       = 1'b0;
    tv_n        = 1'b0;
    tm_n        = 1'b0;
    ec_n        = 1'b0;
    el_n        = 1'b0;
    bad         = 1'b0;

    if (in_valid) begin
      unique case (state)
        ST_HUNT: begin
          if (is_s) state_n = ST_TYPE;
        end
        ST_TYPE: begin
          if (is_hex && kind_legal(nib)) begin
            kind_n      = nib;
            addr_left_n = kind_addr_bytes(nib);
            field_n     = '0;
            state_n     = ST_COUNT;
          end else begin
            bad = 1'b1;
          end
        end
        ST_COUNT: begin
          if (!is_hex) begin
            bad = 1'b1;
          end else if (byte_valid) begin
            sum_n     = byte_in;
            cnt_rem_n = byte_in;
            if ({1'b0, byte_in} < min_cnt || {1'b0, byte_in} > max_cnt) begin
              el_n    = 1'b1;
              state_n = ST_HUNT;
            end else begin
              state_n = ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (!is_hex) begin
            bad = 1'b1;
          end else if (byte_valid) begin
            sum_n       = sum_q + byte_in;
            cnt_rem_n   = cnt_rem - 8'd1;
            field_n     = {field_q[ADDR_W-9:0], byte_in};
            addr_left_n = addr_left - 3'd1;
            if (addr_left == 3'd1) begin
              wptr_n  = {field_q[ADDR_W-9:0], byte_in};
              state_n = ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (!is_hex) begin
            bad = 1'b1;
          end else if (byte_valid) begin
            if (cnt_rem == 8'd1) begin
              csum_ok_n = ((sum_q + byte_in) == 8'hFF);
              state_n   = ST_EOL;
            end else begin
              sum_n     = sum_q + byte_in;
              cnt_rem_n = cnt_rem - 8'd1;
              if (kind_is_data(rec_kind)) begin
                wr_en_n = 1'b1;
                wa_n    = wptr_q;
                wd_n    = byte_in;
                wptr_n  = wptr_q + 1'b1;
              end
            end
          end
        end
        ST_EOL: begin
          if (is_lf) begin
            state_n = ST_HUNT;
            done_n  = 1'b1;
            cerr_n  = !csum_ok_q;
            if (csum_ok_q) begin
              if (kind_is_data(rec_kind)) tally_n = tally_q + 1'b1;
              if (kind_is_start(rec_kind)) begin
                sv_n = 1'b1;
                sa_n = field_q;
              end
              if (rec_kind == 4'd0) hdr_n = 1'b1;
              if (rec_kind == 4'd5) begin
                tv_n = 1'b1;
                tm_n = (field_q[TALLY_W-1:0] != tally_q);
              end
            end
          end else if (!is_cr) begin
            bad = 1'b1;
          end
        end
        default: state_n = ST_HUNT;
      endcase

      if (bad) begin
        ec_n    = 1'b1;
        state_n = is_s ? ST_TYPE : ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state          <= ST_HUNT;
      rec_kind       <= 4'd0;
      cnt_rem        <= 8'd0;
      addr_left      <= 3'd0;
      sum_q          <= 8'd0;
      field_q        <= '0;
      wptr_q         <= '0;
      csum_ok_q      <= 1'b0;
      tally_q        <= '0;
      wr_en          <= 1'b0;
      wr_addr        <= '0;
      wr_data        <= 8'd0;
      rec_done       <= 1'b0;
      rec_csum_err   <= 1'b0;
      start_valid    <= 1'b0;
      start_addr     <= '0;
      hdr_valid      <= 1'b0;
      tally_valid    <= 1'b0;
      tally_mismatch <= 1'b0;
      err_char       <= 1'b0;
      err_len        <= 1'b0;
    end else begin
      state          <= state_n;
      rec_kind       <= kind_n;
      cnt_rem        <= cnt_rem_n;
      addr_left      <= addr_left_n;
      sum_q          <= sum_n;
      field_q        <= field_n;
      wptr_q         <= wptr_n;
      csum_ok_q      <= csum_ok_n;
      tally_q        <= tally_n;
      wr_en          <= wr_en_n;
      if (wr_en_n) begin
        wr_addr <= wa_n;
        wr_data <= wd_n;
      end
      rec_done       <= done_n;
      rec_csum_err   <= cerr_n;
      start_valid    <= sv_n;
      if (sv_n) start_addr <= sa_n;
      hdr_valid      <= hdr_n;
      tally_valid    <= tv_n;
      tally_mismatch <= tm_n;
      err_char       <= ec_n;
      err_len        <= el_n;
    end
  end

endmodule

// File: rtl/srec_loader.sv
module srec_loader
  import srec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TALLY_W  = 16,
  parameter int MAX_DATA = 32,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rec_done,
  output logic [3:0]        rec_kind,
  output logic              rec_csum_err,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_addr,
  output logic              hdr_valid,
  output logic              tally_valid,
  output logic              tally_mismatch,
  output logic              err_char,
  output logic              err_len
);

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                srst_n;
  logic                is_hex, is_s, is_lf, is_cr;
  logic [3:0]          nib;
  logic                pair_clr, byte_valid;
  logic [7:0]          byte_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_LEN-1];

  srec_char_class u_class (
    .ch     (in_char),
    .is_hex (is_hex),
    .nib    (nib),
    .is_s   (is_s),
    .is_lf  (is_lf),
    .is_cr  (is_cr)
  );

  srec_byte_pair u_pair (
    .clk        (clk),
    .srst_n     (srst_n),
    .clr        (pair_clr),
    .nib_valid  (in_valid && is_hex),
    .nib        (nib),
    .byte_valid (byte_valid),
    .byte_out   (byte_val)
  );

  srec_record_fsm #(
    .ADDR_W   (ADDR_W),
    .TALLY_W  (TALLY_W),
    .MAX_DATA (MAX_DATA)
  ) u_fsm (
    .clk            (clk),
    .srst_n         (srst_n),
    .in_valid       (in_valid),
    .is_hex         (is_hex),
    .nib            (nib),
    .is_s           (is_s),
    .is_lf          (is_lf),
    .is_cr          (is_cr),
    .byte_valid     (byte_valid),
    .byte_in        (byte_val),
    .pair_clr       (pair_clr),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .rec_done       (rec_done),
    .rec_kind       (rec_kind),
    .rec_csum_err   (rec_csum_err),
    .start_valid    (start_valid),
    .start_addr     (start_addr),
    .hdr_valid      (hdr_valid),
    .tally_valid    (tally_valid),
    .tally_mismatch (tally_mismatch),
    .err_char       (err_char),
    .err_len        (err_len)
  );

endmodule

// File: rtl/srec_loader_chk.sv
module srec_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        rec_kind,
  input logic              rec_done,
  input logic              rec_csum_err,
  input logic              start_valid,
  input logic              hdr_valid,
  input logic              tally_valid,
  input logic              tally_mismatch,
  input logic              err_char,
  input logic              err_len
);

  AST_WR_DATA_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rec_kind == 4'd1 || rec_kind == 4'd2 || rec_kind == 4'd3)); // R4

  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R4

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_done, err_char, err_len})); // R10

  AST_START_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (rec_done && !rec_csum_err &&
                     (rec_kind == 4'd7 || rec_kind == 4'd8 || rec_kind == 4'd9))); // R6

  AST_HDR_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (rec_done && !rec_csum_err && rec_kind == 4'd0)); // R7

  AST_MISMATCH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    tally_mismatch |-> (tally_valid && rec_kind == 4'd5)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(wr_en || rec_done || err_char || err_len)); // R1

endmodule

bind srec_loader srec_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .rec_kind       (rec_kind),
  .rec_done       (rec_done),
  .rec_csum_err   (rec_csum_err),
  .start_valid    (start_valid),
  .hdr_valid      (hdr_valid),
  .tally_valid    (tally_valid),
  .tally_mismatch (tally_mismatch),
  .err_char       (err_char),
  .err_len        (err_len)
);

// File: tb/tb_srec_loader.sv
module tb_srec_loader;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_char;
  logic        wr_en;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic        rec_done;
  logic [3:0]  rec_kind;
  logic        rec_csum_err;
  logic        start_valid;
  logic [31:0] start_addr;
  logic        hdr_valid;
  logic        tally_valid;
  logic        tally_mismatch;
  logic        err_char;
  logic        err_len;

  srec_loader dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_done(rec_done), .rec_kind(rec_kind), .rec_csum_err(rec_csum_err),
    .start_valid(start_valid), .start_addr(start_addr), .hdr_valid(hdr_valid),
    .tally_valid(tally_valid), .tally_mismatch(tally_mismatch),
    .err_char(err_char), .err_len(err_len)
  );

  // event codes: 1 good done, 2 checksum error done, 3 start, 4 header,
  // 5 tally (value = mismatch), 6 bad character, 7 bad length
  typedef struct {
    int          code;
    logic [31:0] val;
    string       req;
  } ev_t;

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  data;
    string       req;
  } wr_t;

  ev_t         exp_ev[$];
  wr_t         exp_wr[$];
  int          n_chk;
  int          n_fail;
  int          n_obs;
  bit          finished;
  logic [15:0] model_tally;
  logic [7:0]  pay [0:63];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic push_ev(input int code, input logic [31:0] val, input string req);
    ev_t e;
    e.code = code;
    e.val  = val;
    e.req  = req;
    exp_ev.push_back(e);
  endtask

  task automatic observe(input int code, input logic [31:0] val);
    ev_t e;
    n_obs++;
    n_chk++;
    if (exp_ev.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected event: actual code %0d val %h, expected none", code, val);
    end else begin
      e = exp_ev.pop_front();
      if (e.code != code || e.val != val) begin
        n_fail++;
        $display("FAIL %s event: actual code %0d val %h, expected code %0d val %h",
                 e.req, code, val, e.code, e.val);
      end
    end
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    wr_t w;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (wr_en) begin
        n_obs++;
        n_chk++;
        if (exp_wr.size() == 0) begin
          n_fail++;
          $display("FAIL R4 unexpected write: actual %h<=%h, expected none", wr_addr, wr_data);
        end else begin
          w = exp_wr.pop_front();
          if (w.addr != wr_addr || w.data != wr_data) begin
            n_fail++;
            $display("FAIL %s write: actual %h<=%h, expected %h<=%h",
                     w.req, wr_addr, wr_data, w.addr, w.data);
          end
        end
      end
      if (rec_done)    observe(rec_csum_err ? 2 : 1, {28'd0, rec_kind});
      if (start_valid) observe(3, start_addr);
      if (hdr_valid)   observe(4, 32'd0);
      if (tally_valid) observe(5, {31'd0, tally_mismatch});
      if (err_char)    observe(6, 32'd0);
      if (err_len)     observe(7, 32'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    in_char  = 8'h00;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] v, input bit lower);
    if (v < 4'd10) return 8'h30 + {4'd0, v};
    return (lower ? 8'h57 : 8'h37) + {4'd0, v};
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit lower);
    send_char(hexc(b[7:4], lower));
    send_char(hexc(b[3:0], lower));
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  // builds one record, pushes the expected results, then transmits it
  task automatic send_rec(input int t, input logic [31:0] a, input int n,
                          input bit bad_cs, input bit lower, input bit crlf,
                          input string req);
    int         alen;
    logic [7:0] cnt;
    logic [7:0] sum;
    logic [7:0] cs;
    alen = (t == 2 || t == 8) ? 3 : ((t == 3 || t == 7) ? 4 : 2);
    cnt  = 8'(alen + n + 1);
    if (t >= 1 && t <= 3)
      for (int i = 0; i < n; i++) begin
        wr_t w;
        w.addr = a + 32'(i);
        w.data = pay[i];
        w.req  = req;
        exp_wr.push_back(w);
      end
    push_ev(bad_cs ? 2 : 1, 32'(t), req);
    if (!bad_cs) begin
      if (t >= 7) push_ev(3, a, req);
      if (t == 0) push_ev(4, 32'd0, req);
      if (t == 5) push_ev(5, {31'd0, (a[15:0] != model_tally)}, req);
      if (t >= 1 && t <= 3) model_tally = model_tally + 16'd1;
    end
    send_char(8'h53);
    send_char(8'h30 + 8'(t));
    send_byte(cnt, lower);
    sum = cnt;
    for (int i = alen - 1; i >= 0; i--) begin
      sum = sum + a[8*i +: 8];
      send_byte(a[8*i +: 8], lower);
    end
    for (int i = 0; i < n; i++) begin
      sum = sum + pay[i];
      send_byte(pay[i], lower);
    end
    cs = ~sum;
    if (bad_cs) cs = cs ^ 8'h01;
    send_byte(cs, lower);
    if (crlf) send_char(8'h0D);
    send_char(8'h0A);
  endtask

  initial begin
    int obs_before;
    n_chk       = 0;
    n_fail      = 0;
    n_obs       = 0;
    finished    = 1'b0;
    model_tally = 16'd0;
    in_valid    = 1'b0;
    in_char     = 8'h00;
    rst_n       = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    n_chk++;
    if ({wr_en, rec_done, start_valid, hdr_valid, tally_valid, err_char, err_len} != 7'd0) begin
      n_fail++;
      $display("FAIL R12 reset outputs: actual %b, expected 0000000",
               {wr_en, rec_done, start_valid, hdr_valid, tally_valid, err_char, err_len});
    end

    // R1 junk outside a record is ignored
    obs_before = n_obs;
    send_str(" x#9\r");
    send_char(8'h0A);
    idle(4);
    n_chk++;
    if (n_obs != obs_before) begin
      n_fail++;
      $display("FAIL R1 junk produced output: actual %0d events, expected 0", n_obs - obs_before);
    end

    // R7 header; its payload must not be written (R4)
    pay[0] = 8'h51; pay[1] = 8'h52; pay[2] = 8'h53;
    send_rec(0, 32'h0000, 3, 1'b0, 1'b0, 1'b0, "R7");

    // R4 R5 data record with 16 bytes
    for (int i = 0; i < 16; i++) pay[i] = 8'(8'h11 * i + 3);
    send_rec(1, 32'h1000, 16, 1'b0, 1'b0, 1'b0, "R4");

    // R3 R9 three-byte address, lower-case digits
    for (int i = 0; i < 5; i++) pay[i] = 8'(8'hA0 + i);
    send_rec(2, 32'h00_01ABCD, 5, 1'b0, 1'b1, 1'b0, "R9");

    // R3 R11 four-byte address with CR before LF
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'hF0 - i);
    send_rec(3, 32'hDEAD_BEEC, 4, 1'b0, 1'b0, 1'b1, "R11");

    // R5 bad checksum: writes still issued, flagged at the end, not counted
    for (int i = 0; i < 3; i++) pay[i] = 8'(8'h5A ^ i);
    send_rec(1, 32'h2000, 3, 1'b1, 1'b0, 1'b0, "R5");

    // R8 tally agrees (3 good data records), then disagrees
    send_rec(5, 32'h0003, 0, 1'b0, 1'b0, 1'b0, "R8");
    send_rec(5, 32'h0007, 0, 1'b0, 1'b0, 1'b0, "R8");

    // R6 start addresses of every width
    send_rec(9, 32'h0000_0400, 0, 1'b0, 1'b0, 1'b0, "R6");
    send_rec(8, 32'h0012_3456, 0, 1'b0, 1'b0, 1'b0, "R6");
    send_rec(7, 32'h89AB_CDEF, 0, 1'b0, 1'b1, 1'b1, "R6");

    // R10 bad character in the address field, then skip to the next record
    push_ev(6, 32'd0, "R10");
    send_str("S11300G0012");
    pay[0] = 8'h77;
    send_rec(1, 32'h3000, 1, 1'b0, 1'b0, 1'b0, "R10");

    // R10 'S' inside a broken record opens a new one
    push_ev(6, 32'd0, "R10");
    send_str("S11");
    send_rec(9, 32'h0000_1234, 0, 1'b0, 1'b0, 1'b0, "R10");

    // R1 illegal type digit
    push_ev(6, 32'd0, "R1");
    send_str("S4");
    send_char(8'h0A);

    // R10 extra character after the checksum
    push_ev(6, 32'd0, "R10");
    send_str("S9030000FCX");
    send_char(8'h0A);

    // R2 count below minimum and above maximum
    push_ev(7, 32'd0, "R2");
    send_str("S102");
    push_ev(7, 32'd0, "R2");
    send_str("S124");

    // R2 full 32-byte payload (count 35) is legal
    for (int i = 0; i < 32; i++) pay[i] = 8'(255 - 7 * i);
    send_rec(1, 32'hFFF0, 32, 1'b0, 1'b0, 1'b0, "R2");

    // R8 tally now 5 good data records
    send_rec(5, 32'h0005, 0, 1'b0, 1'b0, 1'b0, "R8");

    idle(10);

    n_chk++;
    if (exp_ev.size() != 0 || exp_wr.size() != 0) begin
      n_fail++;
      $display("FAIL R4 pending items: actual %0d events %0d writes left, expected 0 0",
               exp_ev.size(), exp_wr.size());
    end

    finish_run();
  end

endmodule